// File: doc/BRIEF.md
# Programmable Test-Pattern Sequencer

This block plays a small stored program onto a 32-bit pattern bus, one word per clock. Each of its 64 program steps holds a 32-bit data word, a 3-bit opcode and a 9-bit operand N. The opcodes cover a counting ramp, repetition of the step's word, a hold of the present output, an unconditional jump, a subroutine call and return through a 4-entry return stack, and a stop. Steps are written through a simple load port. After reset, execution begins at step 0.

A run input gates stepping, so that low pauses the sequencer without losing its place. An inhibit input drops the output-enable that goes with the bus, for an external tri-state driver, and has no effect on the sequence itself. A sticky halted flag shows that execution has stopped. A separate error flag shows that the stop came from a return-stack overflow or underflow.

Top module: `patseq_top`

## Requirements
- R1: After reset, pat_out is 0, halted and stack_err are 0, and the first step executed is step 0.
- R2: REPEAT (opcode 1) drives the step's data word for N consecutive executing clocks, with N=0 taken as 1, and then moves to the next step (63 wraps to 0).
- R3: COUNT (opcode 0) drives the value X, taken from data bits [8:0] and zero-extended to 32 bits, and adds one on each executing clock. The step ends after the clock that drives N. If X is at least N, it drives X once and moves on.
- R4: HOLD (opcode 2) leaves pat_out unchanged for N executing clocks, with N=0 taken as 1, and then moves to the next step.
- R5: GOTO (opcode 3) drives the step's data word for one clock and continues at step operand[5:0].
- R6: CALL (opcode 4) drives its data word once, saves the following step number and continues at operand[5:0]. RETURN (opcode 5) drives its data word once and continues at the most recently saved step. Up to 4 calls may be pending.
- R7: HALT (opcode 6, and also the unused opcode 7) leaves pat_out unchanged and raises halted. From then until reset, pat_out does not change and halted stays 1, whatever the run input does.
- R8: A CALL with 4 calls already pending, or a RETURN with none pending, leaves pat_out unchanged and raises both stack_err and halted.
- R9: While run is 0, neither pat_out nor the sequencer state changes. When run returns to 1, execution continues exactly where it stopped.
- R10: pat_oe equals the inverse of inhibit, and inhibit has no effect on the sequence.
- R11: A write with prog_we=1 stores prog_data, prog_op and prog_arg into step prog_addr. Each step is read at the time it executes, so a later write replaces the earlier contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_we | input | 1 | Program write strobe |
| prog_addr | input | 6 | Step number to write |
| prog_op | input | 3 | Opcode to store |
| prog_arg | input | 9 | Operand N to store |
| prog_data | input | 32 | Data word to store |
| run | input | 1 | 1 lets the sequencer step, 0 pauses it |
| inhibit | input | 1 | 1 disables the pattern output driver |
| pat_out | output | 32 | Pattern word |
| pat_oe | output | 1 | Output-driver enable |
| halted | output | 1 | Execution has stopped |
| stack_err | output | 1 | The stop came from a return-stack overflow or underflow |

## Verification
The hardest situations to reach from the ports are the two stack faults. A fault needs an exact chain of calls and returns, and random programs almost never build a chain of five pending calls or a return that follows a balanced pair. Directed programs therefore construct both: a nested call pair that unwinds and is followed by one return too many, and a straight chain of five calls. Random programs with random pauses and inhibit pulses then exercise the mix of counters, jumps and calls against a bench model of the step semantics.

// File: rtl/patseq_pkg.sv
package patseq_pkg;
  typedef enum logic [2:0] {
    OP_COUNT  = 3'd0,
    OP_REPEAT = 3'd1,
    OP_HOLD   = 3'd2,
    OP_GOTO   = 3'd3,
    OP_CALL   = 3'd4,
    OP_RET    = 3'd5,
    OP_HALT   = 3'd6
  } op_e;
  localparam int OP_W = 3;
endpackage

// File: rtl/patseq_mem.sv
module patseq_mem #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  parameter int ARG_W  = 9
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [2:0]        wr_op,
  input  logic [ARG_W-1:0]  wr_arg,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [2:0]        rd_op,
  output logic [ARG_W-1:0]  rd_arg,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int WORD_W = 3 + ARG_W + DATA_W;

  logic [WORD_W-1:0] store [DEPTH];

  // one write-enabled register row per step
  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    logic row_we;
    assign row_we = wr_en && (wr_addr == ADDR_W'(g));
    always_ff @(posedge clk) begin
      if (row_we) store[g] <= {wr_op, wr_arg, wr_data};
    end
  end

  logic [WORD_W-1:0] rd_word;
  assign rd_word = store[rd_addr];
  assign rd_data = rd_word[DATA_W-1:0];
  assign rd_arg  = rd_word[DATA_W +: ARG_W];
  assign rd_op   = rd_word[DATA_W+ARG_W +: 3];
endmodule

// File: rtl/patseq_stack.sv
module patseq_stack #(
  parameter int ADDR_W = 6,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [ADDR_W-1:0] push_addr,
  output logic [ADDR_W-1:0] top_addr,
  output logic              full,
  output logic              empty
);
  localparam int SP_W  = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);

  logic [SP_W-1:0]   sp_q, sp_n;
  logic [ADDR_W-1:0] slot [DEPTH];
  logic [IDX_W-1:0]  wr_idx, rd_idx;

  assign wr_idx = IDX_W'(sp_q);
  assign rd_idx = IDX_W'(sp_q - SP_W'(1));
  assign full   = (sp_q == SP_W'(DEPTH));
  assign empty  = (sp_q == '0);
  assign top_addr = slot[rd_idx];

  always_comb begin
    sp_n = sp_q;
    if (push) sp_n = sp_q + SP_W'(1);
    else if (pop) sp_n = sp_q - SP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else if (push || pop) sp_q <= sp_n;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_we;
    assign slot_we = push && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (slot_we) slot[g] <= push_addr;
    end
  end

  p_no_push_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_no_pop_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  p_sp_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sp_q <= SP_W'(DEPTH));
  p_single_op_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (sp_q == $past(sp_q) + SP_W'(1)));
endmodule

// File: rtl/patseq_ctrl.sv
module patseq_ctrl
  import patseq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  parameter int ARG_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [2:0]        op_i,
  input  logic [ARG_W-1:0]  arg_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              push_o,
  output logic              pop_o,
  output logic [ADDR_W-1:0] push_addr_o,
  input  logic [ADDR_W-1:0] top_addr_i,
  input  logic              st_full_i,
  input  logic              st_empty_i,
  output logic [DATA_W-1:0] pat_o,
  output logic              halted_o,
  output logic              err_o
);
  localparam logic [ARG_W-1:0] ONE = ARG_W'(1);

  logic [ADDR_W-1:0] pc_q, pc_n, pc_inc;
  logic              mid_q, mid_n;
  logic [ARG_W-1:0]  cnt_q, cnt_n;
  logic [DATA_W-1:0] pat_q, pat_n;
  logic              halt_q, halt_n;
  logic              err_q, err_n;
  logic              step_en;
  logic [ARG_W-1:0]  rep_eff, cnt_val;

  assign step_en = run_i && !halt_q;
  assign pc_inc  = pc_q + ADDR_W'(1);
  assign rep_eff = mid_q ? cnt_q : ((arg_i == '0) ? ONE : arg_i);
  assign cnt_val = mid_q ? cnt_q : data_i[ARG_W-1:0];

  always_comb begin
    pc_n   = pc_q;
    mid_n  = mid_q;
    cnt_n  = cnt_q;
    pat_n  = pat_q;
    halt_n = halt_q;
    err_n  = err_q;
    push_o = 1'b0;
    pop_o  = 1'b0;
    if (step_en) begin
      case (op_i)
        OP_REPEAT, OP_HOLD: begin
          if (op_i == OP_REPEAT) pat_n = data_i;
          if (rep_eff == ONE) begin
            pc_n  = pc_inc;
            mid_n = 1'b0;
          end else begin
            cnt_n = rep_eff - ONE;
            mid_n = 1'b1;
          end
        end
        OP_COUNT: begin
          pat_n = {{(DATA_W-ARG_W){1'b0}}, cnt_val};
          if (cnt_val >= arg_i) begin
            pc_n  = pc_inc;
            mid_n = 1'b0;
          end else begin
            cnt_n = cnt_val + ONE;
            mid_n = 1'b1;
          end
        end
        OP_GOTO: begin
          pat_n = data_i;
          pc_n  = arg_i[ADDR_W-1:0];
          mid_n = 1'b0;
        end
        OP_CALL: begin
          if (st_full_i) begin
            err_n  = 1'b1;
            halt_n = 1'b1;
          end else begin
            push_o = 1'b1;
            pat_n  = data_i;
            pc_n   = arg_i[ADDR_W-1:0];
            mid_n  = 1'b0;
          end
        end
        OP_RET: begin
          if (st_empty_i) begin
            err_n  = 1'b1;
            halt_n = 1'b1;
          end else begin
            pop_o = 1'b1;
            pat_n = data_i;
            pc_n  = top_addr_i;
            mid_n = 1'b0;
          end
        end
        default: halt_n = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      mid_q  <= 1'b0;
      cnt_q  <= '0;
      pat_q  <= '0;
      halt_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (step_en) begin
      pc_q   <= pc_n;
      mid_q  <= mid_n;
      cnt_q  <= cnt_n;
      pat_q  <= pat_n;
      halt_q <= halt_n;
      err_q  <= err_n;
    end
  end

  assign pc_o        = pc_q;
  assign push_addr_o = pc_inc;
  assign pat_o       = pat_q;
  assign halted_o    = halt_q;
  assign err_o       = err_q;

  p_halt_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |=> (halt_q && $stable(pat_q)));
  p_pause_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> ($stable(pat_q) && $stable(pc_q) && $stable(cnt_q)));
  p_err_halts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> halt_q);
  p_count_ceiling_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && mid_q && op_i == OP_COUNT) |-> (cnt_q <= arg_i));
  p_hold_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && op_i == OP_HOLD) |=> $stable(pat_q));
endmodule

// File: rtl/patseq_top.sv
module patseq_top #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  parameter int ARG_W  = 9,
  parameter int STK_D  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_we,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [2:0]        prog_op,
  input  logic [ARG_W-1:0]  prog_arg,
  input  logic [DATA_W-1:0] prog_data,
  input  logic              run,
  input  logic              inhibit,
  output logic [DATA_W-1:0] pat_out,
  output logic              pat_oe,
  output logic              halted,
  output logic              stack_err
);
  logic [1:0] rst_sync;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  logic [ADDR_W-1:0] pc, push_addr, top_addr;
  logic [2:0]        cur_op;
  logic [ARG_W-1:0]  cur_arg;
  logic [DATA_W-1:0] cur_data;
  logic              push, pop, st_full, st_empty;

  patseq_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .ARG_W(ARG_W)) u_mem (
    .clk(clk), .wr_en(prog_we), .wr_addr(prog_addr), .wr_op(prog_op),
    .wr_arg(prog_arg), .wr_data(prog_data), .rd_addr(pc),
    .rd_op(cur_op), .rd_arg(cur_arg), .rd_data(cur_data)
  );

  patseq_stack #(.ADDR_W(ADDR_W), .DEPTH(STK_D)) u_stack (
    .clk(clk), .rst_n(rst_n_s), .push(push), .pop(pop),
    .push_addr(push_addr), .top_addr(top_addr),
    .full(st_full), .empty(st_empty)
  );

  patseq_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .ARG_W(ARG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .run_i(run), .op_i(cur_op),
    .arg_i(cur_arg), .data_i(cur_data), .pc_o(pc),
    .push_o(push), .pop_o(pop), .push_addr_o(push_addr),
    .top_addr_i(top_addr), .st_full_i(st_full), .st_empty_i(st_empty),
    .pat_o(pat_out), .halted_o(halted), .err_o(stack_err)
  );

  assign pat_oe = !inhibit;
endmodule

// File: tb/patseq_top_bench.sv
`timescale 1ns/1ps
module patseq_top_bench;
  localparam logic [2:0] C_COUNT = 3'd0, C_REP = 3'd1, C_HOLD = 3'd2,
                         C_GOTO = 3'd3, C_CALL = 3'd4, C_RET = 3'd5, C_HALT = 3'd6;

  logic clk = 1'b0;
  logic rst_n, prog_we, run, inhibit;
  logic [5:0]  prog_addr;
  logic [2:0]  prog_op;
  logic [8:0]  prog_arg;
  logic [31:0] prog_data, pat_out;
  logic pat_oe, halted, stack_err;

  always #2.5 clk = ~clk;

  patseq_top u_patseq_top (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_op(prog_op), .prog_arg(prog_arg), .prog_data(prog_data),
    .run(run), .inhibit(inhibit), .pat_out(pat_out), .pat_oe(pat_oe),
    .halted(halted), .stack_err(stack_err)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model of the program and step semantics
  logic [31:0] m_data [64];
  logic [2:0]  m_op   [64];
  logic [8:0]  m_arg  [64];
  logic [5:0]  m_pc;
  bit          m_mid, m_halt, m_err;
  logic [8:0]  m_cnt;
  logic [5:0]  m_stk [4];
  int          m_sp;
  logic [31:0] m_out;
  string       m_tag;

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      C_REP:   return "R2";
      C_COUNT: return "R3";
      C_HOLD:  return "R4";
      C_GOTO:  return "R5";
      C_CALL, C_RET: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic m_reset();
    m_pc = 0; m_mid = 0; m_halt = 0; m_err = 0; m_cnt = 0;
    m_sp = 0; m_out = 0; m_tag = "R1";
  endtask

  task automatic m_adv();
    m_pc = m_pc + 6'd1; m_mid = 0;
  endtask

  task automatic m_step(input bit go);
    logic [2:0] op; logic [8:0] a, eff, v; logic [31:0] d;
    if (!go) begin m_tag = "R9"; return; end
    if (m_halt) begin m_tag = "R7"; return; end
    op = m_op[m_pc]; a = m_arg[m_pc]; d = m_data[m_pc];
    m_tag = tag_of(op);
    case (op)
      C_REP, C_HOLD: begin
        eff = m_mid ? m_cnt : ((a == 0) ? 9'd1 : a);
        if (op == C_REP) m_out = d;
        if (eff == 9'd1) m_adv();
        else begin m_cnt = eff - 9'd1; m_mid = 1; end
      end
      C_COUNT: begin
        v = m_mid ? m_cnt : d[8:0];
        m_out = {23'd0, v};
        if (v >= a) m_adv();
        else begin m_cnt = v + 9'd1; m_mid = 1; end
      end
      C_GOTO: begin m_out = d; m_pc = a[5:0]; m_mid = 0; end
      C_CALL: begin
        if (m_sp == 4) begin m_err = 1; m_halt = 1; m_tag = "R8"; end
        else begin
          m_stk[m_sp] = m_pc + 6'd1; m_sp++;
          m_out = d; m_pc = a[5:0]; m_mid = 0;
        end
      end
      C_RET: begin
        if (m_sp == 0) begin m_err = 1; m_halt = 1; m_tag = "R8"; end
        else begin
          m_sp--; m_pc = m_stk[m_sp]; m_out = d; m_mid = 0;
        end
      end
      default: m_halt = 1;
    endcase
  endtask

  task automatic compare();
    check(pat_out === m_out, m_tag, "pattern", pat_out, m_out);
    check(halted === m_halt, "R7", "halted", {31'd0, halted}, {31'd0, m_halt});
    check(stack_err === m_err, "R8", "stack_err", {31'd0, stack_err}, {31'd0, m_err});
    check(pat_oe === !inhibit, "R10", "pat_oe", {31'd0, pat_oe}, {31'd0, !inhibit});
  endtask

  task automatic do_reset();
    run = 0; inhibit = 0; prog_we = 0;
    prog_addr = 0; prog_op = 0; prog_arg = 0; prog_data = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    m_reset();
  endtask

  task automatic wr(input int addr, input logic [2:0] op, input int arg,
                    input logic [31:0] data);
    @(negedge clk);
    prog_we = 1; prog_addr = 6'(addr); prog_op = op;
    prog_arg = 9'(arg); prog_data = data;
    m_op[addr] = op; m_arg[addr] = 9'(arg); m_data[addr] = data;
    @(negedge clk);
    prog_we = 0;
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 64; i++) wr(i, C_HALT, 0, 32'(i));
  endtask

  // mode 0: paused, 1: always run, k>1: pause on 1 clock in k
  task automatic run_cycles(input int n, input int mode);
    bit r;
    for (int i = 0; i < n; i++) begin
      compare();
      if (mode == 0) r = 0;
      else if (mode == 1) r = 1;
      else r = ($urandom % mode) != 0;
      run = r;
      inhibit = ($urandom % 5) == 0;
      m_step(r);
      @(negedge clk);
    end
    compare();
    run = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset();
    // R1: reset state, step 0 first
    check(pat_out === 32'd0, "R1", "pat_out after reset", pat_out, 32'd0);
    check(halted === 1'b0 && stack_err === 1'b0, "R1", "flags after reset",
          {30'd0, halted, stack_err}, 32'd0);
    clear_prog();
    wr(0, C_REP, 3, 32'hA5A5_0001);
    wr(1, C_COUNT, 256, 32'h0000_00FA);
    wr(2, C_HOLD, 0, 32'hDEAD_0000);
    wr(3, C_HOLD, 4, 32'hDEAD_0001);
    wr(4, C_REP, 0, 32'h0000_1234);
    wr(5, C_GOTO, 8, 32'h5555_5555);
    wr(8, C_CALL, 20, 32'h0000_0008);
    wr(9, C_RET, 0, 32'h0000_0009);
    wr(20, C_CALL, 30, 32'h0000_0020);
    wr(21, C_RET, 0, 32'h0000_0021);
    wr(30, C_REP, 2, 32'h0000_0030);
    wr(31, C_RET, 0, 32'h0000_0031);
    run_cycles(1, 1);
    check(pat_out === 32'hA5A5_0001, "R1", "first step is step 0", pat_out, 32'hA5A5_0001);
    run_cycles(3, 0);
    check(pat_out === 32'hA5A5_0001, "R9", "paused output", pat_out, 32'hA5A5_0001);
    run_cycles(60, 8);
    // R8: return with nothing pending
    check(stack_err === 1'b1 && halted === 1'b1, "R8", "underflow flags",
          {30'd0, halted, stack_err}, 32'd3);
    check(pat_out === 32'h0000_0021, "R8", "underflow leaves output", pat_out, 32'h0000_0021);
    run_cycles(5, 1);

    // R8: fifth nested call
    do_reset();
    clear_prog();
    for (int i = 0; i < 5; i++) wr(i, C_CALL, i + 1, 32'hC000_0000 + 32'(i));
    run_cycles(10, 1);
    check(stack_err === 1'b1, "R8", "overflow flag", {31'd0, stack_err}, 32'd1);
    check(pat_out === 32'hC000_0003, "R8", "overflow leaves output", pat_out, 32'hC000_0003);

    // R3 descending range, R11 rewrite before run
    do_reset();
    clear_prog();
    wr(0, C_COUNT, 5, 32'd10);
    wr(0, C_COUNT, 5, 32'd3);
    run_cycles(1, 1);
    check(pat_out === 32'd3, "R11", "rewritten step used", pat_out, 32'd3);
    run_cycles(4, 1);
    check(pat_out === 32'd5 && halted === 1'b1, "R3", "count end then halt",
          pat_out, 32'd5);
    do_reset();
    clear_prog();
    wr(0, C_COUNT, 5, 32'd10);
    run_cycles(1, 1);
    check(pat_out === 32'd10, "R3", "start above end", pat_out, 32'd10);
    run_cycles(3, 1);
    check(halted === 1'b1 && pat_out === 32'd10, "R7", "halt freezes", pat_out, 32'd10);

    // random programs with random pauses and inhibit
    for (int t = 0; t < 25; t++) begin
      do_reset();
      for (int i = 0; i < 64; i++) begin
        int r; logic [2:0] op; int a; logic [31:0] d;
        r = $urandom % 16;
        d = $urandom;
        if (r < 4)       begin op = C_REP;   a = $urandom % 6; end
        else if (r < 7)  begin op = C_COUNT; a = $urandom % 257;
                               d = {23'd0, 9'(a - ($urandom % 8))}; end
        else if (r < 9)  begin op = C_HOLD;  a = $urandom % 6; end
        else if (r < 11) begin op = C_GOTO;  a = $urandom % 64; end
        else if (r < 13) begin op = C_CALL;  a = $urandom % 64; end
        else if (r < 15) begin op = C_RET;   a = 0; end
        else             begin op = (($urandom % 2) == 0) ? C_HALT : 3'd7; a = 0; end
        wr(i, op, a, d);
      end
      run_cycles(200, 4);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule